// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects seven interrupt sources for a signal-processing core and tells the program sequencer which one to service next. The sources are a startup request, three external active-low pins and three internal request lines from the serial and timer units. Each pin can be set to edge or level sensing. Every source except startup passes through an enable mask. The highest-priority eligible source is presented as a vector address, with the vectors spaced four words apart.

When the sequencer acknowledges an entry, the block saves the arithmetic status word, the mode status word and the current mask on a seven-entry stack, and it marks the claimed source as in service. On a return, the block pops the top entry, restores the mask, presents the saved status words and retires the source in service. A control bit selects one of two servicing rules. In nested servicing, a strictly more urgent source can preempt. In sequential servicing, only one service can run at a time. A write-only force/clear word lets software raise or drop any latched request.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Source 0 has the highest priority and source 6 the lowest. `vector_o` equals the selected index times 4, and it is 0 when `irq_valid_o` is low.
- R2: Mask bit i set to 1 enables source i for i from 1 to 6. Source 0 is always enabled, whatever mask bit 0 holds.
- R3: `irq_valid_o` is low whenever no source is pending, enabled and allowed by the servicing rule.
- R4: Control bit k (k = 0..2) set to 1 makes pin `ext_n_i[k]` edge-sensitive. A high-to-low transition latches the request until it is claimed or cleared. With the bit at 0, the request is pending only while the pin is low and is not latched. Pins 0, 1 and 2 feed sources 1, 4 and 5. Internal lines 0, 1 and 2 feed sources 2, 3 and 6, and `boot_req_i` feeds source 0. The internal lines and `boot_req_i` latch on any high cycle.
- R5: With control bit 3 at 0 (sequential), no source is selected while any service is active.
- R6: With control bit 3 at 1 (nested), a source is selected only if its priority is strictly higher than every service in progress.
- R7: `ack_i` pushes {astat, mstat, mask} and raises `depth_o` by one. If a source is selected, it claims that source: its latch is cleared and it is marked in service. A new latch set in the same cycle survives the claim.
- R8: `rti_i` pops the top entry. From the next cycle the mask is restored, the saved words appear on `saved_astat_o`/`saved_mstat_o`, and the most urgent service in progress is retired.
- R9: A write to the force/clear word sets latches from bits [6:0] and clears latches from bits [13:7] (bit 7+i clears source i). A set wins over a clear in the same cycle.
- R10: An acknowledge at depth 7 sets the sticky `ovf_o`, stores nothing and leaves the depth at 7.
- R11: A return at depth 0 sets the sticky `unf_o` and leaves the depth and the mask unchanged.
- R12: After reset, the mask and control word are 0, no request is latched, the depth is 0 and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| boot_req_i | input | 1 | Startup request (source 0) |
| ext_n_i | input | 3 | External active-low request pins |
| int_req_i | input | 3 | Internal request lines |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 7 | Mask write data |
| ctrl_we_i | input | 1 | Control write strobe |
| ctrl_wdata_i | input | 4 | [2:0] edge select, [3] nested mode |
| fc_we_i | input | 1 | Force/clear write strobe |
| fc_wdata_i | input | 14 | [6:0] force, [13:7] clear |
| astat_i | input | 16 | Arithmetic status to save |
| mstat_i | input | 16 | Mode status to save |
| ack_i | input | 1 | Service entry acknowledge |
| rti_i | input | 1 | Return from service |
| irq_valid_o | output | 1 | A source is selected |
| vector_o | output | 14 | Vector address of the selected source |
| mask_o | output | 7 | Current mask |
| depth_o | output | 3 | Stack occupancy |
| ovf_o | output | 1 | Sticky stack overflow |
| unf_o | output | 1 | Sticky stack underflow |
| saved_astat_o | output | 16 | Arithmetic status from the last pop |
| saved_mstat_o | output | 16 | Mode status from the last pop |

## Verification
Two events can land in the same cycle: the acknowledge that claims an edge-latched source, and a fresh falling edge on that source's own pin. The bench latches source 1 through a falling edge on pin 0 and releases the pin. It then asserts `ack_i` and pulls the pin low again in the same cycle. It judges the outcome by two observations. In nested mode the claimed source must not reappear while it is in service. After the return, the source must come back with vector 4, which shows the new edge outlived the claim.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int NSRC   = 7;
    localparam int NEXT   = 3;
    localparam int NINT   = 3;
    localparam int SW     = 16;
    localparam int DEPTH  = 7;
    localparam int VA_W   = 14;
    localparam int IDX_W  = $clog2(NSRC);
    localparam int LVL_W  = $clog2(DEPTH + 1);
    localparam int CTRL_W = NEXT + 1;

    // Source index fed by external pin k and by internal line k.
    function automatic int ext_src(input int k);
        return (k == 0) ? 1 : k + 3;
    endfunction

    function automatic int int_src(input int k);
        return (k < 2) ? k + 2 : 6;
    endfunction
endpackage

// File: rtl/irqc_capture.sv
module irqc_capture
    import irqc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            boot_req_i,
    input  logic [NEXT-1:0] ext_n_i,
    input  logic [NINT-1:0] int_req_i,
    input  logic [NEXT-1:0] edge_sel_i,
    input  logic [NSRC-1:0] force_i,
    input  logic [NSRC-1:0] clear_i,
    output logic [NSRC-1:0] pend_o
);
    typedef struct packed {
        logic [NSRC-1:0] lat;
        logic [NEXT-1:0] prev;
    } cap_t;

    cap_t            cap_d, cap_q;
    logic [NSRC-1:0] set_v, lvl_v;

    always_comb begin
        cap_d    = cap_q;
        set_v    = force_i;
        lvl_v    = '0;
        set_v[0] = set_v[0] | boot_req_i;
        for (int k = 0; k < NEXT; k++) begin
            if (edge_sel_i[k])
                set_v[ext_src(k)] = set_v[ext_src(k)] | (cap_q.prev[k] & ~ext_n_i[k]);
            else
                lvl_v[ext_src(k)] = ~ext_n_i[k];
        end
        for (int k = 0; k < NINT; k++)
            set_v[int_src(k)] = set_v[int_src(k)] | int_req_i[k];
        cap_d.lat  = (cap_q.lat & ~clear_i) | set_v;
        cap_d.prev = ext_n_i;
        pend_o     = cap_q.lat | lvl_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q.lat  <= '0;
            cap_q.prev <= '1;
        end else begin
            cap_q <= cap_d;
        end
    end
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
    import irqc_pkg::*;
(
    input  logic [NSRC-1:0]  req_i,
    output logic [NSRC-1:0]  grant_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             valid_o
);
    always_comb begin
        grant_o = '0;
        idx_o   = '0;
        valid_o = 1'b0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                grant_o    = '0;
                grant_o[i] = 1'b1;
                idx_o      = IDX_W'(i);
                valid_o    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irqc_stack.sv
module irqc_stack
    import irqc_pkg::*;
#(
    parameter int EW = 2 * SW + NSRC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [EW-1:0]    din_i,
    output logic [EW-1:0]    top_o,
    output logic [LVL_W-1:0] lvl_o,
    output logic             ovf_o,
    output logic             unf_o
);
    localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][EW-1:0] mem;
        logic [LVL_W-1:0]         lvl;
        logic                     ovf;
        logic                     unf;
    } stk_t;

    stk_t stk_d, stk_q;

    always_comb begin
        stk_d = stk_q;
        if (pop_i) begin
            if (stk_q.lvl == '0) stk_d.unf = 1'b1;
            else                 stk_d.lvl = stk_q.lvl - 1'b1;
        end
        if (push_i) begin
            if (stk_d.lvl == FULL) begin
                stk_d.ovf = 1'b1;
            end else begin
                stk_d.mem[stk_d.lvl] = din_i;
                stk_d.lvl            = stk_d.lvl + 1'b1;
            end
        end
        top_o = (stk_q.lvl == '0) ? '0 : stk_q.mem[stk_q.lvl - 1'b1];
        lvl_o = stk_q.lvl;
        ovf_o = stk_q.ovf;
        unf_o = stk_q.unf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stk_q <= '0;
        else        stk_q <= stk_d;
    end

    p_level_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stk_q.lvl <= FULL);
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && stk_q.lvl == FULL) |=> (stk_q.ovf && stk_q.lvl == FULL));
    p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stk_q.ovf |=> stk_q.ovf);
    p_empty_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && stk_q.lvl == '0) |=> (stk_q.unf && stk_q.lvl == '0));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_req_i,
    input  logic [NEXT-1:0]   ext_n_i,
    input  logic [NINT-1:0]   int_req_i,
    input  logic              mask_we_i,
    input  logic [NSRC-1:0]   mask_wdata_i,
    input  logic              ctrl_we_i,
    input  logic [CTRL_W-1:0] ctrl_wdata_i,
    input  logic              fc_we_i,
    input  logic [2*NSRC-1:0] fc_wdata_i,
    input  logic [SW-1:0]     astat_i,
    input  logic [SW-1:0]     mstat_i,
    input  logic              ack_i,
    input  logic              rti_i,
    output logic              irq_valid_o,
    output logic [VA_W-1:0]   vector_o,
    output logic [NSRC-1:0]   mask_o,
    output logic [LVL_W-1:0]  depth_o,
    output logic              ovf_o,
    output logic              unf_o,
    output logic [SW-1:0]     saved_astat_o,
    output logic [SW-1:0]     saved_mstat_o
);
    localparam int EW = 2 * SW + NSRC;

    typedef struct packed {
        logic [NSRC-1:0] mask;
        logic            nest;
        logic [NEXT-1:0] edge_sel;
        logic [NSRC-1:0] act;
        logic [SW-1:0]   pa;
        logic [SW-1:0]   pm;
    } top_t;

    top_t             st_d, st_q;
    logic [NSRC-1:0]  pend, allow, elig, grant, force_v, clear_v;
    logic [IDX_W-1:0] sel_idx;
    logic             sel_valid, claim, blocked, retired;
    logic [EW-1:0]    top_entry;

    irqc_capture u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .boot_req_i (boot_req_i),
        .ext_n_i    (ext_n_i),
        .int_req_i  (int_req_i),
        .edge_sel_i (st_q.edge_sel),
        .force_i    (force_v),
        .clear_i    (clear_v),
        .pend_o     (pend)
    );

    irqc_arbiter u_arb (
        .req_i   (elig),
        .grant_o (grant),
        .idx_o   (sel_idx),
        .valid_o (sel_valid)
    );

    irqc_stack #(.EW(EW)) u_stk (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (ack_i),
        .pop_i  (rti_i),
        .din_i  ({astat_i, mstat_i, st_q.mask}),
        .top_o  (top_entry),
        .lvl_o  (depth_o),
        .ovf_o  (ovf_o),
        .unf_o  (unf_o)
    );

    always_comb begin
        blocked = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            blocked  = blocked | st_q.act[i];
            allow[i] = st_q.nest ? ~blocked : (st_q.act == '0);
        end
        elig    = pend & (st_q.mask | NSRC'(1)) & allow;
        claim   = ack_i & sel_valid;
        force_v = fc_we_i ? fc_wdata_i[NSRC-1:0] : '0;
        clear_v = (fc_we_i ? fc_wdata_i[2*NSRC-1:NSRC] : '0) | (claim ? grant : '0);

        st_d    = st_q;
        retired = 1'b0;
        if (rti_i) begin
            for (int i = 0; i < NSRC; i++) begin
                if (st_q.act[i] && !retired) begin
                    st_d.act[i] = 1'b0;
                    retired     = 1'b1;
                end
            end
            if (depth_o != '0) begin
                {st_d.pa, st_d.pm, st_d.mask} = top_entry;
            end
        end
        if (claim)     st_d.act  = st_d.act | grant;
        if (mask_we_i) st_d.mask = mask_wdata_i;
        if (ctrl_we_i) begin
            st_d.edge_sel = ctrl_wdata_i[NEXT-1:0];
            st_d.nest     = ctrl_wdata_i[NEXT];
        end

        irq_valid_o   = sel_valid;
        vector_o      = sel_valid ? (VA_W'(sel_idx) << 2) : '0;
        mask_o        = st_q.mask;
        saved_astat_o = st_q.pa;
        saved_mstat_o = st_q.pm;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_seq_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.nest && st_q.act != '0) |-> !irq_valid_o);
    p_nest_strict_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.nest && irq_valid_o) |-> ((st_q.act & ~({NSRC{1'b1}} << (sel_idx + 1'b1))) == '0));
    p_ack_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !rti_i && depth_o < LVL_W'(DEPTH)) |=> depth_o == $past(depth_o) + 1'b1);
    p_claim_marks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_valid_o) |=> st_q.act[$past(sel_idx)]);
endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_req_i = 1'b0;
    logic [2:0]  ext_n_i = 3'b111;
    logic [2:0]  int_req_i = '0;
    logic        mask_we_i = 1'b0;
    logic [6:0]  mask_wdata_i = '0;
    logic        ctrl_we_i = 1'b0;
    logic [3:0]  ctrl_wdata_i = '0;
    logic        fc_we_i = 1'b0;
    logic [13:0] fc_wdata_i = '0;
    logic [15:0] astat_i = '0;
    logic [15:0] mstat_i = '0;
    logic        ack_i = 1'b0;
    logic        rti_i = 1'b0;
    logic        irq_valid_o;
    logic [13:0] vector_o;
    logic [6:0]  mask_o;
    logic [2:0]  depth_o;
    logic        ovf_o, unf_o;
    logic [15:0] saved_astat_o, saved_mstat_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irq_vector_ctrl u_dut (.*);

    // {mask, force, expected valid, expected index}
    localparam logic [17:0] TBL [0:5] = '{
        {7'h7F, 7'h06, 1'b1, 3'd1},
        {7'h7C, 7'h06, 1'b1, 3'd2},
        {7'h00, 7'h40, 1'b0, 3'd0},
        {7'h00, 7'h01, 1'b1, 3'd0},
        {7'h40, 7'h60, 1'b1, 3'd6},
        {7'h30, 7'h70, 1'b1, 3'd4}
    };

    task automatic chk(input string tag, input logic [31:0] a, input logic [31:0] e);
        checks++;
        if (a !== e) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, a, e);
        end
    endtask

    task automatic wr_mask(input logic [6:0] v);
        @(negedge clk); mask_we_i = 1'b1; mask_wdata_i = v;
        @(negedge clk); mask_we_i = 1'b0;
    endtask

    task automatic wr_ctrl(input logic [3:0] v);
        @(negedge clk); ctrl_we_i = 1'b1; ctrl_wdata_i = v;
        @(negedge clk); ctrl_we_i = 1'b0;
    endtask

    task automatic wr_fc(input logic [13:0] v);
        @(negedge clk); fc_we_i = 1'b1; fc_wdata_i = v;
        @(negedge clk); fc_we_i = 1'b0;
    endtask

    task automatic do_ack(input logic [15:0] a, input logic [15:0] m);
        @(negedge clk); ack_i = 1'b1; astat_i = a; mstat_i = m;
        @(negedge clk); ack_i = 1'b0;
    endtask

    task automatic do_rti();
        @(negedge clk); rti_i = 1'b1;
        @(negedge clk); rti_i = 1'b0;
    endtask

    task automatic chk_sel(input string tag, input logic v, input int idx);
        chk({tag, " valid"}, irq_valid_o, v);
        chk({tag, " vector"}, vector_o, v ? idx * 4 : 0);
    endtask

    function automatic logic [13:0] clr(input int s);
        return 14'(1) << (7 + s);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 valid", irq_valid_o, 0);
        chk("R12 mask", mask_o, 0);
        chk("R12 depth", depth_o, 0);
        chk("R12 ovf", ovf_o, 0);
        chk("R12 unf", unf_o, 0);

        // R1 R2 R3 R9: table of mask/force patterns
        for (int t = 0; t < 6; t++) begin
            wr_fc(14'h3F80);
            wr_mask(TBL[t][17:11]);
            wr_fc({7'h00, TBL[t][10:4]});
            chk_sel($sformatf("R1 R2 R3 row%0d", t), TBL[t][3], int'(TBL[t][2:0]));
        end

        // R4 internal line latches
        wr_fc(14'h3F80);
        wr_mask(7'h7F);
        @(negedge clk); int_req_i[0] = 1'b1;
        @(negedge clk); int_req_i[0] = 1'b0;
        @(negedge clk);
        chk_sel("R4 internal latched", 1, 2);
        wr_fc(clr(2));
        chk_sel("R9 clear internal", 0, 0);

        // R4 level and edge pins, nested mode
        wr_ctrl(4'b1001);
        @(negedge clk); ext_n_i[1] = 1'b0;
        @(negedge clk); chk_sel("R4 level low", 1, 4);
        ext_n_i[1] = 1'b1;
        @(negedge clk); chk_sel("R4 level released", 0, 0);
        ext_n_i[0] = 1'b0;
        @(negedge clk); chk_sel("R4 edge fall", 1, 1);
        ext_n_i[0] = 1'b1;
        @(negedge clk); chk_sel("R4 edge held", 1, 1);

        // R7 acknowledge, R6 nesting
        do_ack(16'h1111, 16'h2222);
        chk("R7 depth", depth_o, 1);
        chk_sel("R7 claimed", 0, 0);
        wr_fc(14'h0002);
        chk_sel("R6 equal blocked", 0, 0);
        wr_fc(clr(1));
        wr_fc(14'h0004);
        chk_sel("R6 lower blocked", 0, 0);
        wr_fc(14'h0001);
        chk_sel("R6 higher preempts", 1, 0);
        do_ack(16'h3333, 16'h4444);
        chk("R7 depth2", depth_o, 2);
        wr_mask(7'h00);
        chk("R8 mask cleared", mask_o, 0);

        // R8 return
        do_rti();
        chk("R8 mask restored", mask_o, 7'h7F);
        chk("R8 astat", saved_astat_o, 16'h3333);
        chk("R8 mstat", saved_mstat_o, 16'h4444);
        chk("R8 depth", depth_o, 1);
        chk_sel("R6 still blocked", 0, 0);
        do_rti();
        chk("R8 depth0", depth_o, 0);
        chk("R8 astat2", saved_astat_o, 16'h1111);
        chk_sel("R8 pending resumes", 1, 2);

        // R5 sequential mode
        wr_ctrl(4'b0000);
        do_ack(16'h0, 16'h0);
        wr_fc(14'h0001);
        chk_sel("R5 sequential blocks", 0, 0);
        do_rti();
        chk_sel("R5 after return", 1, 0);
        do_ack(16'h0, 16'h0);
        do_rti();
        chk_sel("R5 idle", 0, 0);

        // R9 force then clear
        wr_fc(14'h0008);
        chk_sel("R9 forced", 1, 3);
        wr_fc(clr(3));
        chk_sel("R9 cleared", 0, 0);
        wr_fc(14'h0020 | clr(5));
        chk_sel("R9 set wins", 1, 5);
        wr_fc(clr(5));

        // R7 claim colliding with a new edge
        wr_ctrl(4'b1001);
        @(negedge clk); ext_n_i[0] = 1'b0;
        @(negedge clk); ext_n_i[0] = 1'b1;
        @(negedge clk); chk_sel("R7 pre-collision", 1, 1);
        ack_i = 1'b1; ext_n_i[0] = 1'b0;
        @(negedge clk); ack_i = 1'b0; ext_n_i[0] = 1'b1;
        @(negedge clk);
        chk("R7 collision depth", depth_o, 1);
        chk_sel("R7 collision in service", 0, 0);
        do_rti();
        chk_sel("R7 new edge kept", 1, 1);
        wr_fc(14'h3F80);

        // R10 overflow, R11 underflow
        wr_ctrl(4'b0000);
        wr_mask(7'h00);
        for (int i = 1; i <= 7; i++) do_ack(16'(i), 16'h0);
        chk("R10 full depth", depth_o, 7);
        chk("R10 no ovf yet", ovf_o, 0);
        do_ack(16'd8, 16'h0);
        chk("R10 ovf", ovf_o, 1);
        chk("R10 depth held", depth_o, 7);
        do_rti();
        chk("R10 top not stored", saved_astat_o, 7);
        for (int i = 0; i < 6; i++) do_rti();
        chk("R11 empty", depth_o, 0);
        chk("R11 no unf yet", unf_o, 0);
        wr_mask(7'h55);
        do_rti();
        chk("R11 unf", unf_o, 1);
        chk("R11 depth", depth_o, 0);
        chk("R11 mask kept", mask_o, 7'h55);
        chk("R10 ovf sticky", ovf_o, 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule